// File: doc/BRIEF.md
# Planar Display Memory Access Mapper

This block sits between a processor's byte access port and a display memory built from four separate byte-wide planes that share one offset. Every access through the 64K-address window is turned into a registered request on the plane side: one offset bus per plane, a per-plane enable, a per-plane write strobe and the write byte copied to every plane. Read data comes back from the plane that the access selected.

Two mappings are supported and picked per access by a mode input. In the linear (chained) mapping, consecutive window addresses walk across the planes, so a single address always reaches exactly one byte cell: the two low address bits name the plane and the remaining bits form the offset. In the planar (unchained) mapping, a window address is the offset itself and reaches the same cell in all four planes at once. Screen pixel n then lives at offset n/4 in plane n mod 4. A write touches only the planes that a 4-bit write mask enables, and a read returns the plane that a 2-bit select names. A 320x200 frame takes 16000 offsets per plane when planar and 64000 addresses when linear. The full window reaches 256K bytes when planar.

Top module: `plane_access_mapper`

## Requirements
- R1: While reset is asserted and after it is released with no access, planeEn and planeWe are all zero and every planeAddr bus is zero.
- R2: An access sampled at a rising clock edge appears on the plane side in the following cycle. A cycle with neither cpuWrEn nor cpuRdEn leaves planeEn and planeWe all zero.
- R3: A linear write (chainMode=1) asserts planeEn and planeWe for plane cpuAddr[1:0] only, and drives offset cpuAddr[15:2] (zero-extended) on the plane buses.
- R4: A planar write (chainMode=0) drives offset cpuAddr on every plane. Bit i of planeMask enables and write-strobes plane i, and planes with a clear bit keep their contents.
- R5: A planar write with planeMask equal to 0000 asserts no planeEn or planeWe bit and changes no memory cell.
- R6: A linear read enables only plane cpuAddr[1:0] at offset cpuAddr[15:2], asserts no planeWe, and returns that plane's byte on cpuRdData.
- R7: A planar read enables only plane rdPlaneSel at offset cpuAddr, ignores planeMask, asserts no planeWe, and returns that plane's byte.
- R8: When cpuWrEn and cpuRdEn are both high, the access is treated as a write.
- R9: During a write, every planeWrData bus carries the written byte.
- R10: cpuRdData keeps showing the byte of the last access's selected plane and offset through idle cycles.
- R11: A byte written linearly at address n is read back planar at offset n/4 with rdPlaneSel = n mod 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| chainMode | input | 1 | 1 = linear mapping, 0 = planar mapping |
| cpuAddr | input | 16 | Window address |
| cpuWrData | input | 8 | Byte to write |
| cpuWrEn | input | 1 | Write request |
| cpuRdEn | input | 1 | Read request |
| planeMask | input | 4 | Planar write mask, bit i = plane i |
| rdPlaneSel | input | 2 | Planar read plane |
| cpuRdData | output | 8 | Byte read back |
| planeAddr | output | 4x16 | Offset bus per plane |
| planeEn | output | 4 | Plane access enable |
| planeWe | output | 4 | Plane write strobe |
| planeWrData | output | 4x8 | Write byte per plane |
| planeRdData | input | 4x8 | Read byte per plane |

## Verification
The bench goes after the address split at its edges, address 0xFFFF in both mappings, and consecutive linear addresses that must spread across all four planes at the same offset. A design that swapped the offset and plane fields would strobe the wrong plane there. It also drives an all-zero planar mask, which a design that took the mask for "all planes" would turn into a four-plane overwrite. It reads the same cells back planar after a linear write, which a wrong shift would miss. It raises read and write together, which a read-first design would handle without a write strobe. It also sets a full mask during a planar read, which a design would wrongly follow if it let the mask steer reads.

// File: rtl/planemap_pkg.sv
package planemap_pkg;
  typedef struct packed {
    logic load;
    logic write;
    logic chained;
  } accCtl_t;
endpackage

// File: rtl/planemap_ctl.sv
module planemap_ctl
  import planemap_pkg::*;
#(
  parameter int PLANES = 4,
  localparam int SEL_W = $clog2(PLANES)
) (
  input  logic              chainMode,
  input  logic [SEL_W-1:0]  addrLow,
  input  logic              cpuWrEn,
  input  logic              cpuRdEn,
  input  logic [PLANES-1:0] planeMask,
  input  logic [SEL_W-1:0]  rdPlaneSel,
  output accCtl_t           ctl,
  output logic [PLANES-1:0] hitMask,
  output logic [SEL_W-1:0]  selPlane
);
  always_comb begin
    ctl.load    = cpuWrEn | cpuRdEn;
    ctl.write   = cpuWrEn;
    ctl.chained = chainMode;
    selPlane    = chainMode ? addrLow : rdPlaneSel;
  end

  for (genvar p = 0; p < PLANES; p++) begin : g_hit
    localparam logic [SEL_W-1:0] PIDX = SEL_W'(p);
    always_comb begin
      if (chainMode)    hitMask[p] = (addrLow == PIDX);
      else if (cpuWrEn) hitMask[p] = planeMask[p];
      else              hitMask[p] = (rdPlaneSel == PIDX);
    end
  end

  always_comb begin
    if (chainMode) AST_CHAIN_ONE_PLANE: assert ($onehot(hitMask)); // R3
  end
endmodule

// File: rtl/planemap_dp.sv
module planemap_dp
  import planemap_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(PLANES)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  accCtl_t                        ctl,
  input  logic [PLANES-1:0]              hitMask,
  input  logic [SEL_W-1:0]               selPlane,
  input  logic [ADDR_W-1:0]              cpuAddr,
  input  logic [DATA_W-1:0]              cpuWrData,
  input  logic [PLANES-1:0][DATA_W-1:0]  planeRdData,
  output logic [PLANES-1:0][ADDR_W-1:0]  planeAddr,
  output logic [PLANES-1:0]              planeEn,
  output logic [PLANES-1:0]              planeWe,
  output logic [PLANES-1:0][DATA_W-1:0]  planeWrData,
  output logic [DATA_W-1:0]              cpuRdData
);
  logic [ADDR_W-1:0] offNext, offReg;
  logic [DATA_W-1:0] wrDataReg;
  logic [PLANES-1:0] enReg, weReg;
  logic [SEL_W-1:0]  selReg;

  always_comb begin
    if (ctl.chained) offNext = ADDR_W'(cpuAddr >> SEL_W);
    else             offNext = cpuAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReg    <= '0;
      wrDataReg <= '0;
      selReg    <= '0;
      enReg     <= '0;
      weReg     <= '0;
    end else begin
      enReg <= ctl.load ? hitMask : '0;
      weReg <= (ctl.load && ctl.write) ? hitMask : '0;
      if (ctl.load) begin
        offReg <= offNext;
        selReg <= selPlane;
        if (ctl.write) wrDataReg <= cpuWrData;
      end
    end
  end

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    assign planeAddr[p]   = offReg;
    assign planeWrData[p] = wrDataReg;
  end

  assign planeEn   = enReg;
  assign planeWe   = weReg;
  assign cpuRdData = planeRdData[selReg];

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> (planeEn == '0 && planeWe == '0)); // R2
  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.write) |=> (planeWe == '0)); // R6
  AST_CHAIN_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.chained) |=> (planeAddr[0] == ($past(cpuAddr) >> SEL_W))); // R3
endmodule

// File: rtl/plane_access_mapper.sv
module plane_access_mapper
  import planemap_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(PLANES)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           chainMode,
  input  logic [ADDR_W-1:0]              cpuAddr,
  input  logic [DATA_W-1:0]              cpuWrData,
  input  logic                           cpuWrEn,
  input  logic                           cpuRdEn,
  input  logic [PLANES-1:0]              planeMask,
  input  logic [SEL_W-1:0]               rdPlaneSel,
  output logic [DATA_W-1:0]              cpuRdData,
  output logic [PLANES-1:0][ADDR_W-1:0]  planeAddr,
  output logic [PLANES-1:0]              planeEn,
  output logic [PLANES-1:0]              planeWe,
  output logic [PLANES-1:0][DATA_W-1:0]  planeWrData,
  input  logic [PLANES-1:0][DATA_W-1:0]  planeRdData
);
  accCtl_t           ctl;
  logic [PLANES-1:0] hitMask;
  logic [SEL_W-1:0]  selPlane;

  planemap_ctl #(.PLANES(PLANES)) i_ctl (
    .chainMode (chainMode),
    .addrLow   (cpuAddr[SEL_W-1:0]),
    .cpuWrEn   (cpuWrEn),
    .cpuRdEn   (cpuRdEn),
    .planeMask (planeMask),
    .rdPlaneSel(rdPlaneSel),
    .ctl       (ctl),
    .hitMask   (hitMask),
    .selPlane  (selPlane)
  );

  planemap_dp #(.PLANES(PLANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .hitMask    (hitMask),
    .selPlane   (selPlane),
    .cpuAddr    (cpuAddr),
    .cpuWrData  (cpuWrData),
    .planeRdData(planeRdData),
    .planeAddr  (planeAddr),
    .planeEn    (planeEn),
    .planeWe    (planeWe),
    .planeWrData(planeWrData),
    .cpuRdData  (cpuRdData)
  );

  AST_PLANAR_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && !chainMode) |=> (planeWe == $past(planeMask))); // R4
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && !chainMode && planeMask == '0) |=> (planeEn == '0)); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && cpuRdEn && chainMode) |=> ($countones(planeWe) == 1)); // R8
endmodule

// File: tb/test_plane_access_mapper.sv
module test_plane_access_mapper;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chainMode = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0] cpuWrData = '0;
  logic cpuWrEn = 1'b0, cpuRdEn = 1'b0;
  logic [3:0] planeMask = '0;
  logic [1:0] rdPlaneSel = '0;
  logic [7:0] cpuRdData;
  logic [3:0][15:0] planeAddr;
  logic [3:0] planeEn, planeWe;
  logic [3:0][7:0] planeWrData;
  logic [3:0][7:0] planeRdData;

  logic [7:0] memArr [4][65536];
  logic [7:0] refMem [4][65536];

  int compared = 0, mismatched = 0;

  typedef struct {
    string req;
    logic [3:0] en, we;
    bit chkAddr; logic [15:0] addr;
    bit chkWd;   logic [7:0] wd;
    bit chkRd;   logic [7:0] rd;
  } item_t;
  item_t sbq[$];
  logic [7:0] lastRd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plane_access_mapper i_plane_access_mapper (
    .clk(clk), .rstN(rstN), .chainMode(chainMode), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn),
    .planeMask(planeMask), .rdPlaneSel(rdPlaneSel), .cpuRdData(cpuRdData),
    .planeAddr(planeAddr), .planeEn(planeEn), .planeWe(planeWe),
    .planeWrData(planeWrData), .planeRdData(planeRdData)
  );

  always @(posedge clk)
    for (int p = 0; p < 4; p++)
      if (planeWe[p]) memArr[p][planeAddr[p]] <= planeWrData[p];

  always_comb
    for (int p = 0; p < 4; p++) planeRdData[p] = memArr[p][planeAddr[p]];

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: applies one access at a falling edge and queues its expectation.
  task automatic access(bit wr, bit rd, bit chain, logic [15:0] a, logic [7:0] d,
                        logic [3:0] m, logic [1:0] s, string req);
    item_t it;
    logic [1:0] pl;
    logic [15:0] off;
    @(negedge clk);
    chainMode = chain; cpuAddr = a; cpuWrData = d; cpuWrEn = wr; cpuRdEn = rd;
    planeMask = m; rdPlaneSel = s;
    it.req = req; it.chkAddr = 1; it.chkWd = wr; it.wd = d; it.chkRd = 0; it.rd = '0;
    off = chain ? (a >> 2) : a;
    pl  = chain ? a[1:0] : s;
    it.addr = off;
    if (wr) begin
      it.en = chain ? (4'b1 << a[1:0]) : m;
      it.we = it.en;
      for (int p = 0; p < 4; p++) if (it.we[p]) refMem[p][off] = d;
    end else if (rd) begin
      it.en = 4'b1 << pl; it.we = '0;
      it.chkRd = 1; it.rd = refMem[pl][off]; lastRd = it.rd;
    end else begin
      it.en = '0; it.we = '0; it.chkAddr = 0;
    end
    sbq.push_back(it);
  endtask

  task automatic idle(bit holdRd, string req);
    item_t it;
    @(negedge clk);
    cpuWrEn = 0; cpuRdEn = 0;
    it.req = req; it.en = '0; it.we = '0; it.chkAddr = 0; it.addr = '0;
    it.chkWd = 0; it.wd = '0; it.chkRd = holdRd; it.rd = lastRd;
    sbq.push_back(it);
  endtask

  // Monitor: pops one expectation per cycle just after the clock edge.
  initial begin
    item_t it;
    forever begin
      @(posedge clk); #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        chk(it.req, "planeEn", 16'(planeEn), 16'(it.en));
        chk(it.req, "planeWe", 16'(planeWe), 16'(it.we));
        if (it.chkAddr)
          for (int p = 0; p < 4; p++) chk(it.req, "planeAddr", planeAddr[p], it.addr);
        if (it.chkWd)
          for (int p = 0; p < 4; p++) chk("R9", "planeWrData", 16'(planeWrData[p]), 16'(it.wd));
        if (it.chkRd) chk(it.req, "cpuRdData", 16'(cpuRdData), 16'(it.rd));
      end
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired: actual running expected finished");
    finishRun();
  end

  initial begin
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 65536; i++) begin memArr[p][i] = '0; refMem[p][i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1", "planeEn in reset", 16'(planeEn), 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "planeEn", 16'(planeEn), 16'h0);
    chk("R1", "planeWe", 16'(planeWe), 16'h0);
    chk("R1", "planeAddr", planeAddr[2], 16'h0);

    access(1, 0, 1, 16'h1235, 8'hA5, 4'h0, 2'd0, "R3");
    for (int i = 0; i < 4; i++) access(1, 0, 1, 16'(i), 8'(8'h10 + i), 4'h0, 2'd0, "R3");
    access(1, 0, 1, 16'hFFFF, 8'h77, 4'h0, 2'd0, "R3");
    access(0, 1, 1, 16'h1235, 8'h00, 4'h0, 2'd0, "R6");
    idle(1, "R10");
    idle(1, "R2");
    access(0, 1, 1, 16'h0002, 8'h00, 4'h0, 2'd0, "R6");

    access(1, 0, 0, 16'h0100, 8'h3C, 4'b1010, 2'd0, "R4");
    access(1, 0, 0, 16'h0100, 8'hFF, 4'b0000, 2'd0, "R5");
    for (int s = 0; s < 4; s++) access(0, 1, 0, 16'h0100, 8'h00, 4'b1111, 2'(s), "R7");
    access(1, 0, 0, 16'hFFFF, 8'hC3, 4'b1111, 2'd0, "R4");
    access(0, 1, 0, 16'hFFFF, 8'h00, 4'b0000, 2'd2, "R7");

    access(1, 1, 1, 16'h2001, 8'h5A, 4'h0, 2'd0, "R8");
    access(1, 1, 0, 16'h0300, 8'h6B, 4'b0100, 2'd1, "R8");
    access(0, 1, 0, 16'h0300, 8'h00, 4'h0, 2'd2, "R8");

    for (int n = 40; n < 48; n++) access(1, 0, 1, 16'(n), 8'(8'hA0 + n), 4'h0, 2'd0, "R11");
    for (int n = 40; n < 48; n++) access(0, 1, 0, 16'(n / 4), 8'h00, 4'h0, 2'(n % 4), "R11");

    for (int k = 0; k < 60; k++) begin
      logic [15:0] a;
      a = 16'($urandom_range(0, 255));
      if (k % 2 == 0) access(1, 0, 0, a, 8'($urandom), 4'($urandom), 2'd0, "R4");
      else            access(0, 1, 0, a, 8'h00, 4'($urandom), 2'($urandom), "R7");
    end
    idle(0, "R2");
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule